// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog timer that sits on a simple register bus. A counter advances on each pulse of a slow tick enable, nominally one per millisecond. If it climbs to a programmed timeout before software refreshes it, the block raises a reset request. The request is held for a fixed number of bus clocks. After that the whole block returns to its reset state.

Software cannot refresh the counter or change the configuration by an ordinary write. Both actions need a key written to the command/counter register. In 32-bit command mode the key is one full word. In 16-bit command mode it is two halves on consecutive cycles, low half first. Any other value written there, or a gap between the halves, trips the reset at once.

Control and timeout writes land only while an unlock window is open. The window opens on the unlock key, provided the update-allowed bit is still set. It shuts after a parameterised number of cycles, or earlier on the first control write. Three enumerated state machines carry the behaviour:

- **Key sequencer.** States: KS_IDLE, KS_UL_HALF, KS_RF_HALF.
  - Transitions: idle to a half-state on a matching low half.
  - Either half-state returns to idle on the next cycle. The return emits a hit when the high half matches and a fault otherwise.
- **Window machine.** States: WN_SHUT, WN_OPEN, WN_DONE.
  - The unlock grant leads from shut or done to open.
  - A control write or window expiry leads from open to done.
  - A fresh grant while open restarts the window.
- **Trip machine.** States: TR_ARMED, TR_HOLD.
  - A fault or timeout moves armed to hold.
  - Expiry of the hold count returns it to armed and wipes the block.

Top module: `kwd_top`

## Requirements
- R1: Register addresses are control 0x0, counter/command 0x4 and timeout 0x8.
  - After reset, control reads 0x000000A0: bit 7 is enable, bit 5 is update-allowed, and bit 13 (32-bit command mode) is 0.
  - The counter reads 0, the timeout reads 0x400, and rst_req is low.
- R2: A write to the control or timeout register while the window is not open leaves the register unchanged. Control bit 11 reads 1 exactly while the window is open.
- R3: In 16-bit mode, writing 0xC520 and then 0xD928 to the counter register on consecutive cycles opens the window. Only bits 15:0 are compared.
- R4: In 32-bit mode (control bit 13 = 1), a single write of 0xD928C520 opens the window, and a single write of 0xB480A602 refreshes.
- R5: The window stays open for WIN_CYC cycles after the key completes, or until one accepted control write, whichever is first. Afterwards bit 11 reads 0 and bit 10 (reconfiguration done) reads 1.
- R6: While enable is 1, each tick pulse adds one to the counter, which reads back at 0x4. With enable 0 the counter holds.
- R7: A refresh clears the counter to 0. In 16-bit mode the refresh key is 0xA602 followed by 0xB480.
- R8: When enabled and the counter equals or exceeds the timeout, rst_req rises. It is high from the second cycle after the tick that made the counter reach the timeout.
- R9: A wrong value written to the counter register, or a 16-bit first half not followed on the very next cycle by its matching second half, raises rst_req on the following cycle.
- R10: rst_req stays high for exactly HOLD_CYC cycles. When it falls, every register is back at its R1 value.
- R11: Once update-allowed is 0, later unlock keys leave the window shut and timeout writes are ignored.
- R12: bus_rdata is 0 while bus_re is low and when an unmapped address is read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | bus clock |
| rst_n | input | 1 | asynchronous active-low reset |
| tick | input | 1 | single-cycle counting enable |
| bus_addr | input | ADDR_W | register byte address |
| bus_we | input | 1 | write strobe |
| bus_re | input | 1 | read strobe |
| bus_wdata | input | 32 | write data |
| bus_rdata | output | 32 | read data, combinational |
| rst_req | output | 1 | registered reset request |

## Verification
The bench builds the block with WIN_CYC = 12 and HOLD_CYC = 5. These small values let it sweep every write offset across the whole unlock window and two cycles beyond. They also let it time the full reset hold and the return to reset after every trip.

Timeouts of 1 to 6 ticks are swept, alternating 16-bit and 32-bit command mode. At each tick the bench predicts the reset request arithmetically from the tick count.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
    localparam int OFS_CTRL = 0;
    localparam int OFS_CNT  = 4;
    localparam int OFS_TOV  = 8;

    localparam int B_CMD32 = 13;
    localparam int B_UNLK  = 11;
    localparam int B_DONE  = 10;
    localparam int B_EN    = 7;
    localparam int B_UPD   = 5;

    localparam logic [15:0] UL_LO = 16'hC520;
    localparam logic [15:0] UL_HI = 16'hD928;
    localparam logic [15:0] RF_LO = 16'hA602;
    localparam logic [15:0] RF_HI = 16'hB480;

    typedef enum logic [1:0] {KS_IDLE, KS_UL_HALF, KS_RF_HALF} key_st_e;
    typedef enum logic [1:0] {WN_SHUT, WN_OPEN, WN_DONE} win_st_e;
    typedef enum logic {TR_ARMED, TR_HOLD} trip_st_e;

    typedef struct packed {
        logic cmd32;
        logic en;
        logic upd_ok;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{cmd32: 1'b0, en: 1'b1, upd_ok: 1'b1};
endpackage

// File: rtl/kwd_keyseq.sv
module kwd_keyseq (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wipe,
    input  logic        cmd32,
    input  logic        wr_cmd,
    input  logic [31:0] wdata,
    output logic        unlock_hit,
    output logic        refresh_hit,
    output logic        key_fault
);
    import kwd_pkg::*;

    key_st_e st, st_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    st <= KS_IDLE;
        else if (wipe) st <= KS_IDLE;
        else           st <= st_nx;
    end

    // next state and key outcome
    always_comb begin
        st_nx       = st;
        unlock_hit  = 1'b0;
        refresh_hit = 1'b0;
        key_fault   = 1'b0;
        unique case (st)
            KS_IDLE: begin
                if (wr_cmd) begin
                    if (cmd32) begin
                        if (wdata == {UL_HI, UL_LO})      unlock_hit  = 1'b1;
                        else if (wdata == {RF_HI, RF_LO}) refresh_hit = 1'b1;
                        else                              key_fault   = 1'b1;
                    end else begin
                        if (wdata[15:0] == UL_LO)      st_nx     = KS_UL_HALF;
                        else if (wdata[15:0] == RF_LO) st_nx     = KS_RF_HALF;
                        else                           key_fault = 1'b1;
                    end
                end
            end
            KS_UL_HALF: begin
                st_nx = KS_IDLE;
                if (wr_cmd && wdata[15:0] == UL_HI) unlock_hit = 1'b1;
                else                                key_fault  = 1'b1;
            end
            KS_RF_HALF: begin
                st_nx = KS_IDLE;
                if (wr_cmd && wdata[15:0] == RF_HI) refresh_hit = 1'b1;
                else                                key_fault   = 1'b1;
            end
            default: st_nx = KS_IDLE;
        endcase
    end

    // R3
    half_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st != KS_IDLE && !wipe) |=> (st == KS_IDLE));
endmodule

// File: rtl/kwd_unlock.sv
module kwd_unlock #(
    parameter int WIN_CYC = 255
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wipe,
    input  logic unlock_hit,
    input  logic upd_ok,
    input  logic ctrl_wr,
    output logic is_open,
    output logic cfg_done
);
    import kwd_pkg::*;

    localparam int WW = $clog2(WIN_CYC + 1);
    localparam logic [WW-1:0] WIN_LAST = WW'(WIN_CYC - 1);

    win_st_e st, st_nx;
    logic [WW-1:0] win_cnt;
    logic grant;

    assign grant = unlock_hit && upd_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    st <= WN_SHUT;
        else if (wipe) st <= WN_SHUT;
        else           st <= st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                win_cnt <= '0;
        else if (wipe || grant)    win_cnt <= '0;
        else if (st == WN_OPEN)    win_cnt <= win_cnt + 1'b1;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            WN_SHUT, WN_DONE: if (grant) st_nx = WN_OPEN;
            WN_OPEN: begin
                if (ctrl_wr)                  st_nx = WN_DONE;
                else if (grant)               st_nx = WN_OPEN;
                else if (win_cnt == WIN_LAST) st_nx = WN_DONE;
            end
            default: st_nx = WN_SHUT;
        endcase
    end

    always_comb begin
        is_open  = (st == WN_OPEN);
        cfg_done = (st == WN_DONE);
    end

    // R5
    ctrl_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == WN_OPEN && ctrl_wr && !wipe) |=> (st == WN_DONE));
    // R11
    upd_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (unlock_hit && !upd_ok && st != WN_OPEN && !wipe) |=> $stable(st));
endmodule

// File: rtl/kwd_count.sv
module kwd_count #(
    parameter int CNT_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wipe,
    input  logic             tick,
    input  logic             en,
    input  logic             clear,
    input  logic [CNT_W-1:0] tov,
    output logic [CNT_W-1:0] cnt,
    output logic             reached
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt <= '0;
        else if (wipe || clear)  cnt <= '0;
        else if (en && tick)     cnt <= cnt + 1'b1;
    end

    assign reached = en && (cnt >= tov);
endmodule

// File: rtl/kwd_trip.sv
module kwd_trip #(
    parameter int HOLD_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fault,
    output logic rst_req,
    output logic wipe
);
    import kwd_pkg::*;

    localparam int HW = $clog2(HOLD_CYC + 1);
    localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_CYC - 1);

    trip_st_e st, st_nx;
    logic [HW-1:0] hcnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= TR_ARMED;
        else        st <= st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             hcnt <= '0;
        else if (st == TR_HOLD) hcnt <= hcnt + 1'b1;
        else                    hcnt <= '0;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            TR_ARMED: if (fault)             st_nx = TR_HOLD;
            TR_HOLD:  if (hcnt == HOLD_LAST) st_nx = TR_ARMED;
            default:  st_nx = TR_ARMED;
        endcase
    end

    always_comb begin
        rst_req = (st == TR_HOLD);
        wipe    = (st == TR_HOLD) && (hcnt == HOLD_LAST);
    end

    // R10
    hold_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req) |-> (hcnt == '0));
endmodule

// File: rtl/kwd_top.sv
module kwd_top #(
    parameter int              ADDR_W   = 4,
    parameter int              CNT_W    = 17,
    parameter int              WIN_CYC  = 255,
    parameter int              HOLD_CYC = 16,
    parameter logic [CNT_W-1:0] TOV_RST = 17'h400
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              rst_req
);
    import kwd_pkg::*;

    logic hit_ctrl, hit_cnt, hit_tov;
    logic wipe, is_open, cfg_done;
    logic unlock_hit, refresh_hit, key_fault, reached, ctrl_wr;
    ctrl_t ctrl_q;
    logic [CNT_W-1:0] tov_q, cnt;

    assign hit_ctrl = (bus_addr == ADDR_W'(OFS_CTRL));
    assign hit_cnt  = (bus_addr == ADDR_W'(OFS_CNT));
    assign hit_tov  = (bus_addr == ADDR_W'(OFS_TOV));
    assign ctrl_wr  = bus_we && hit_ctrl && is_open;

    kwd_keyseq u_keys (
        .clk(clk), .rst_n(rst_n), .wipe(wipe), .cmd32(ctrl_q.cmd32),
        .wr_cmd(bus_we && hit_cnt), .wdata(bus_wdata),
        .unlock_hit(unlock_hit), .refresh_hit(refresh_hit), .key_fault(key_fault)
    );

    kwd_unlock #(.WIN_CYC(WIN_CYC)) u_win (
        .clk(clk), .rst_n(rst_n), .wipe(wipe), .unlock_hit(unlock_hit),
        .upd_ok(ctrl_q.upd_ok), .ctrl_wr(ctrl_wr),
        .is_open(is_open), .cfg_done(cfg_done)
    );

    kwd_count #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .wipe(wipe), .tick(tick), .en(ctrl_q.en),
        .clear(refresh_hit), .tov(tov_q), .cnt(cnt), .reached(reached)
    );

    kwd_trip #(.HOLD_CYC(HOLD_CYC)) u_trip (
        .clk(clk), .rst_n(rst_n), .fault(key_fault || reached),
        .rst_req(rst_req), .wipe(wipe)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RST;
            tov_q  <= TOV_RST;
        end else if (wipe) begin
            ctrl_q <= CTRL_RST;
            tov_q  <= TOV_RST;
        end else begin
            if (ctrl_wr)
                ctrl_q <= '{cmd32: bus_wdata[B_CMD32], en: bus_wdata[B_EN],
                            upd_ok: bus_wdata[B_UPD]};
            if (bus_we && hit_tov && is_open)
                tov_q <= bus_wdata[CNT_W-1:0];
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_re) begin
            if (hit_ctrl) begin
                bus_rdata[B_CMD32] = ctrl_q.cmd32;
                bus_rdata[B_UNLK]  = is_open;
                bus_rdata[B_DONE]  = cfg_done;
                bus_rdata[B_EN]    = ctrl_q.en;
                bus_rdata[B_UPD]   = ctrl_q.upd_ok;
            end else if (hit_cnt) begin
                bus_rdata[CNT_W-1:0] = cnt;
            end else if (hit_tov) begin
                bus_rdata[CNT_W-1:0] = tov_q;
            end
        end
    end

    // R2
    locked_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && hit_ctrl && !is_open && !wipe) |=> $stable(ctrl_q));
    // R7
    refresh_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (refresh_hit && !wipe) |=> (cnt == '0));
    // R8
    timeout_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reached && !rst_req) |=> rst_req);
    // R9
    key_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (key_fault && !rst_req) |=> rst_req);
    // R10
    rst_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_req) |-> (tov_q == TOV_RST && cnt == '0 && ctrl_q == CTRL_RST));
endmodule

// File: tb/kwd_top_test.sv
`timescale 1ns/1ps
module kwd_top_test;
    localparam int WIN  = 12;
    localparam int HOLD = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rst_req;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] rv;
    logic [31:0] prev_tov;
    int hl;

    always #2.5 clk = ~clk;

    kwd_top #(.ADDR_W(4), .CNT_W(17), .WIN_CYC(WIN), .HOLD_CYC(HOLD),
              .TOV_RST(17'h400)) uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_re(bus_re), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .rst_req(rst_req)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk);
        #1 bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_re = 1'b1;
        #1 d = bus_rdata;
        bus_re = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic tick1;
        @(negedge clk);
        tick = 1'b1;
        @(posedge clk);
        #1 tick = 1'b0;
    endtask

    task automatic unlock(input bit m32);
        if (m32) wr(4'h4, 32'hD928C520);
        else begin wr(4'h4, 32'h0000C520); wr(4'h4, 32'h0000D928); end
    endtask

    task automatic refresh(input bit m32);
        if (m32) wr(4'h4, 32'hB480A602);
        else begin wr(4'h4, 32'h0000A602); wr(4'h4, 32'h0000B480); end
    endtask

    // called at a negedge where rst_req is high
    task automatic hold_len(output int n);
        n = 0;
        while (rst_req === 1'b1 && n < 100) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic after_trip(input string tag);
        hold_len(hl);
        chk({tag, " R10 hold length"}, hl, HOLD);
        rd(4'h0, rv); chk({tag, " R10 ctrl back to reset"}, rv, 32'h0A0);
        rd(4'h8, rv); chk({tag, " R10 timeout back to reset"}, rv, 32'h400);
        rd(4'h4, rv); chk({tag, " R10 counter back to zero"}, rv, 32'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        idle(3);
        @(negedge clk) rst_n = 1'b1;
        idle(2);

        // R1 reset state
        rd(4'h0, rv); chk("R1 ctrl reset", rv, 32'h0A0);
        rd(4'h4, rv); chk("R1 counter reset", rv, 32'h0);
        rd(4'h8, rv); chk("R1 timeout reset", rv, 32'h400);
        chk("R1 rst_req low", {31'b0, rst_req}, 32'h0);
        // R12 read gating and unmapped address
        @(negedge clk); bus_addr = 4'h8; bus_re = 1'b0;
        #1 chk("R12 rdata zero without read", bus_rdata, 32'h0);
        rd(4'hC, rv); chk("R12 unmapped reads zero", rv, 32'h0);

        // R2 locked writes ignored
        wr(4'h8, 32'h5); rd(4'h8, rv); chk("R2 locked timeout write", rv, 32'h400);
        wr(4'h0, 32'h0); rd(4'h0, rv); chk("R2 locked ctrl write", rv, 32'h0A0);

        // R3 16-bit unlock, R5 closure by ctrl write
        unlock(1'b0);
        rd(4'h0, rv); chk("R3 unlocked flag", rv, 32'h8A0);
        wr(4'h8, 32'h3); rd(4'h8, rv); chk("R2 open timeout write", rv, 32'h3);
        wr(4'h0, 32'h20A0); rd(4'h0, rv); chk("R5 closed by ctrl write", rv, 32'h24A0);
        wr(4'h8, 32'h7); rd(4'h8, rv); chk("R5 locked after close", rv, 32'h3);

        // R4 32-bit keys, R6 counting
        unlock(1'b1);
        rd(4'h0, rv); chk("R4 32-bit unlock", rv, 32'h28A0);
        wr(4'h8, 32'h4); wr(4'h0, 32'h20A0);
        refresh(1'b1);
        repeat (3) tick1;
        rd(4'h4, rv); chk("R6 counter after 3 ticks", rv, 32'h3);
        refresh(1'b1);
        rd(4'h4, rv); chk("R4 32-bit refresh clears", rv, 32'h0);
        repeat (3) tick1;
        idle(2);
        chk("R8 no trip below timeout", {31'b0, rst_req}, 32'h0);

        // R6 disable holds counter
        unlock(1'b1);
        wr(4'h0, 32'h2020);
        rd(4'h0, rv); chk("R6 disabled ctrl", rv, 32'h2420);
        repeat (6) tick1;
        idle(2);
        rd(4'h4, rv); chk("R6 counter held while disabled", rv, 32'h3);
        chk("R6 no trip while disabled", {31'b0, rst_req}, 32'h0);

        // R9 wrong 32-bit key
        wr(4'h4, 32'h12345678);
        @(negedge clk);
        chk("R9 wrong 32-bit key trips", {31'b0, rst_req}, 32'h1);
        after_trip("bad32");

        // R7 16-bit refresh
        repeat (2) tick1;
        rd(4'h4, rv); chk("R6 counter after 2 ticks", rv, 32'h2);
        refresh(1'b0);
        rd(4'h4, rv); chk("R7 16-bit refresh clears", rv, 32'h0);

        // R9 gap between halves
        wr(4'h4, 32'h0000C520);
        @(negedge clk);
        chk("R9 no trip before gap seen", {31'b0, rst_req}, 32'h0);
        @(negedge clk);
        chk("R9 gap trips", {31'b0, rst_req}, 32'h1);
        after_trip("gap16");

        // R9 wrong second half
        wr(4'h4, 32'h0000A602); wr(4'h4, 32'h00001234);
        @(negedge clk);
        chk("R9 wrong second half trips", {31'b0, rst_req}, 32'h1);
        after_trip("half16");

        // R9 wrong first half
        wr(4'h4, 32'h00000001);
        @(negedge clk);
        chk("R9 wrong first half trips", {31'b0, rst_req}, 32'h1);
        after_trip("first16");

        // R8 timeout sweep 1..6, alternating command width
        for (int t = 1; t <= 6; t++) begin
            bit m32;
            m32 = t[0];
            unlock(1'b0);
            wr(4'h8, t);
            wr(4'h0, m32 ? 32'h20A0 : 32'h00A0);
            refresh(m32);
            for (int k = 1; k <= t; k++) begin
                tick1;
                @(negedge clk);
                @(negedge clk);
                chk($sformatf("R8 t=%0d k=%0d trip", t, k), {31'b0, rst_req},
                    (k >= t) ? 32'h1 : 32'h0);
                if (k < t) begin
                    rd(4'h4, rv); chk($sformatf("R6 t=%0d k=%0d count", t, k), rv, k);
                end else begin
                    after_trip($sformatf("sweep t=%0d", t));
                end
            end
        end

        // R5 window sweep
        prev_tov = 32'h400;
        for (int j = 1; j <= WIN + 2; j++) begin
            logic [31:0] want;
            unlock(1'b0);
            idle(j - 1);
            wr(4'h8, 32'(100 + j));
            want = (j <= WIN) ? 32'(100 + j) : prev_tov;
            rd(4'h8, rv); chk($sformatf("R5 window offset %0d", j), rv, want);
            prev_tov = want;
            wr(4'h0, 32'h0A0);
            rd(4'h0, rv); chk($sformatf("R5 closed flags offset %0d", j), rv, 32'h4A0);
        end

        // R11 update-allowed cleared
        unlock(1'b0);
        wr(4'h0, 32'h080);
        rd(4'h0, rv); chk("R11 ctrl after clearing update", rv, 32'h480);
        unlock(1'b0);
        rd(4'h0, rv); chk("R11 unlock ignored", rv, 32'h480);
        wr(4'h8, 32'h9);
        rd(4'h8, rv); chk("R11 timeout write ignored", rv, prev_tov);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule